// File: doc/BRIEF.md
# MOVE Bus-Cycle Sequencer

This block turns a decoded data-move instruction into the ordered stream of external bus cycles that a 16-bit-bus processor runs for it. Effective-address arithmetic and decode happen elsewhere. The block needs only the source class, the destination class, the operand size, the number of source extension words, the number of internal idle clocks that come before the first bus cycle, and the supervisor state. The block issues one request at a time. Each request carries:
- a direction (read or write);
- a program/data space tag;
- a three-bit function code;
- a byte flag.

It holds every request until the bus acknowledges it. When the last cycle is acknowledged, it pulses a done flag together with the instruction length in clocks.

The normal order has six parts:
1. internal idle clocks;
2. source extension-word prefetches;
3. source operand cycles;
4. destination extension-word prefetches;
5. operand writes;
6. one final prefetch.

A memory source paired with an absolute-long destination uses a different order. After the source reads, the block prefetches only one destination extension word. It then writes the operand and follows the write with two prefetches. This happens because the second prefetch moves behind the write cycles.

The controller is one state machine with states IDLE, WAIT (internal idle clocks), SEXT (source extension prefetch), SOP (source operand), DEXT (destination extension prefetch), WR (operand write), TAIL (closing prefetch) and DONE. The transitions are as follows:
- IDLE→first non-empty phase, on start.
- Each phase→the next non-empty phase in the order above, on the acknowledge of its last cycle, or in WAIT on its last idle clock.
- TAIL→DONE.
- DONE→IDLE, always after one clock.

Phases with a count of zero are skipped. TAIL is never empty.

Top module: `move_seq`

## Requirements
- R1: After reset, req_valid_o, idle_o and done_o are low.
- R2: Every case except the interleaved one runs in this order:
  - lead_idle_i idle clocks;
  - src_ext_i program reads;
  - the source operand cycles;
  - the destination extension program reads (2 for absolute long, dst_class_i=2; 1 for absolute short, dst_class_i=3; 0 for register, dst_class_i=0, or indirect, dst_class_i=1);
  - the operand writes, when dst_class_i is not 0;
  - exactly one program read.
- R3: With a memory source (src_class_i = 2 or 3) and dst_class_i=2, the block runs in this order: the source operand reads, one program read, all operand writes, then two program reads. This holds for all three sizes. The byte case with one source extension word, two idle clocks and four-clock bus cycles totals 26 clocks.
- R4: A register source (src_class_i=0) has no operand cycles. An immediate source (src_class_i=1) fetches its operand words as program reads. Both use the R2 order, even with dst_class_i=2.
- R5: size_i: 0 = byte, 1 = word, 2 = long, 3 = word. A long operand takes two consecutive word cycles. Only data-space operand cycles of a byte move raise req_byte_o. Program reads are always word.
- R6: With super_i latched high at start, req_fc_o is 6 for program and 5 for data cycles. With super_i latched low, it is 2 for program and 1 for data cycles.
- R7: A request and its attributes stay unchanged until ack_i is sampled high with it. An ack_i with no request pending has no effect.
- R8: idle_o is high for exactly lead_idle_i clocks before the first request, and no request is raised while it is high.
- R9: done_o is high for one clock, in the clock after the last acknowledge. len_o then equals the number of clocks from the one after start acceptance through the last acknowledge.
- R10: start_i is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in IDLE |
| src_class_i | input | 2 | 0 register, 1 immediate, 2/3 memory |
| dst_class_i | input | 2 | 0 register, 1 indirect, 2 absolute long, 3 absolute short |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 word |
| src_ext_i | input | EXT_W | Source extension words |
| lead_idle_i | input | IDLE_W | Idle clocks before first bus cycle |
| super_i | input | 1 | Supervisor state |
| ack_i | input | 1 | Bus acknowledge |
| req_valid_o | output | 1 | Bus request pending |
| req_write_o | output | 1 | 1 write, 0 read |
| req_prog_o | output | 1 | 1 program space, 0 data space |
| req_fc_o | output | 3 | Function code |
| req_byte_o | output | 1 | Byte-size cycle |
| idle_o | output | 1 | Internal idle clock |
| done_o | output | 1 | Sequence complete pulse |
| len_o | output | LEN_W | Instruction length in clocks, valid with done_o |

## Verification
A wrong phase count or a wrong phase successor shows on the ports at the first acknowledge it affects. That acknowledge is followed by a request whose direction or space tag differs from the expected stream, or by an early or missing done pulse. The bench compares against its model on every clock, so such a fault is reported in the clock it appears. A wrong latched supervisor or size value shows on the first request of the affected space, through req_fc_o or req_byte_o. A faulty clock counter shows only at done_o, through len_o.

// File: rtl/move_seq_pkg.sv
package move_seq_pkg;

    localparam int PCW = 4;

    localparam logic [1:0] SRC_REG  = 2'd0;
    localparam logic [1:0] SRC_IMM  = 2'd1;
    localparam logic [1:0] DST_REG  = 2'd0;
    localparam logic [1:0] DST_ABSL = 2'd2;
    localparam logic [1:0] DST_ABSS = 2'd3;
    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_LONG  = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WAIT = 3'd1,
        S_SEXT = 3'd2,
        S_SOP  = 3'd3,
        S_DEXT = 3'd4,
        S_WR   = 3'd5,
        S_TAIL = 3'd6,
        S_DONE = 3'd7
    } st_e;

    typedef struct packed {
        logic [PCW-1:0] n_idle;
        logic [PCW-1:0] n_sext;
        logic [PCW-1:0] n_sop;
        logic [PCW-1:0] n_dext;
        logic [PCW-1:0] n_wr;
        logic [PCW-1:0] n_tail;
        logic           src_imm;
        logic           op_byte;
    } plan_t;

    // First phase after 'cur' whose count is non-zero.
    function automatic st_e next_phase(st_e cur, plan_t p);
        st_e n;
        if (cur < S_WAIT && p.n_idle != '0)
            n = S_WAIT;
        else if (cur < S_SEXT && p.n_sext != '0)
            n = S_SEXT;
        else if (cur < S_SOP && p.n_sop != '0)
            n = S_SOP;
        else if (cur < S_DEXT && p.n_dext != '0)
            n = S_DEXT;
        else if (cur < S_WR && p.n_wr != '0)
            n = S_WR;
        else if (cur < S_TAIL)
            n = S_TAIL;
        else
            n = S_DONE;
        return n;
    endfunction

    function automatic logic [PCW-1:0] cnt_of(st_e s, plan_t p);
        logic [PCW-1:0] c;
        unique case (s)
            S_WAIT:  c = p.n_idle;
            S_SEXT:  c = p.n_sext;
            S_SOP:   c = p.n_sop;
            S_DEXT:  c = p.n_dext;
            S_WR:    c = p.n_wr;
            S_TAIL:  c = p.n_tail;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/move_seq_plan.sv
module move_seq_plan
    import move_seq_pkg::*;
#(
    parameter int EXT_W  = 2,
    parameter int IDLE_W = 3
) (
    input  logic [1:0]        src_class_i,
    input  logic [1:0]        dst_class_i,
    input  logic [1:0]        size_i,
    input  logic [EXT_W-1:0]  src_ext_i,
    input  logic [IDLE_W-1:0] lead_idle_i,
    output plan_t             plan_o
);

    logic [PCW-1:0] n_op;
    logic           src_mem;
    logic           interleave;

    always_comb begin
        n_op       = (size_i == SZ_LONG) ? PCW'(2) : PCW'(1);
        src_mem    = src_class_i[1];
        interleave = src_mem && (dst_class_i == DST_ABSL);

        plan_o.n_idle  = PCW'(lead_idle_i);
        plan_o.n_sext  = PCW'(src_ext_i);
        plan_o.n_sop   = (src_class_i == SRC_REG) ? '0 : n_op;
        unique case (dst_class_i)
            DST_ABSL: plan_o.n_dext = interleave ? PCW'(1) : PCW'(2);
            DST_ABSS: plan_o.n_dext = PCW'(1);
            default:  plan_o.n_dext = '0;
        endcase
        plan_o.n_wr    = (dst_class_i == DST_REG) ? '0 : n_op;
        plan_o.n_tail  = interleave ? PCW'(2) : PCW'(1);
        plan_o.src_imm = (src_class_i == SRC_IMM);
        plan_o.op_byte = (size_i == SZ_BYTE);
    end

endmodule

// File: rtl/move_seq_attr.sv
module move_seq_attr (
    input  logic       in_bus_i,
    input  logic       is_wr_i,
    input  logic       is_prog_i,
    input  logic       op_byte_i,
    input  logic       sup_i,
    output logic       valid_o,
    output logic       write_o,
    output logic       prog_o,
    output logic [2:0] fc_o,
    output logic       byte_o
);

    always_comb begin
        valid_o = in_bus_i;
        write_o = in_bus_i && is_wr_i;
        prog_o  = in_bus_i && is_prog_i;
        byte_o  = in_bus_i && op_byte_i && !is_prog_i;
        fc_o    = in_bus_i ? {sup_i, is_prog_i, !is_prog_i} : 3'd0;
    end

endmodule

// File: rtl/move_seq_clkcnt.sv
module move_seq_clkcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= '0;
        else if (inc_i)
            cnt_o <= cnt_o + W'(1);
    end

endmodule

// File: rtl/move_seq.sv
module move_seq
    import move_seq_pkg::*;
#(
    parameter int EXT_W  = 2,
    parameter int IDLE_W = 3,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        src_class_i,
    input  logic [1:0]        dst_class_i,
    input  logic [1:0]        size_i,
    input  logic [EXT_W-1:0]  src_ext_i,
    input  logic [IDLE_W-1:0] lead_idle_i,
    input  logic              super_i,
    input  logic              ack_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic              req_prog_o,
    output logic [2:0]        req_fc_o,
    output logic              req_byte_o,
    output logic              idle_o,
    output logic              done_o,
    output logic [LEN_W-1:0]  len_o
);

    st_e            st_q, st_d;
    plan_t          plan_in, plan_q, plan_cur;
    logic [PCW-1:0] left_q, left_d;
    logic           sup_q;
    logic           accept, in_bus, step, is_wr, is_prog;
    logic [LEN_W-1:0] cnt;

    move_seq_plan #(.EXT_W(EXT_W), .IDLE_W(IDLE_W)) u_plan (
        .src_class_i (src_class_i),
        .dst_class_i (dst_class_i),
        .size_i      (size_i),
        .src_ext_i   (src_ext_i),
        .lead_idle_i (lead_idle_i),
        .plan_o      (plan_in)
    );

    assign accept   = (st_q == S_IDLE) && start_i;
    assign plan_cur = (st_q == S_IDLE) ? plan_in : plan_q;

    // Next state and phase counter
    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        in_bus = 1'b0;
        step   = 1'b0;
        unique case (st_q)
            S_IDLE: step = start_i;
            S_WAIT: step = 1'b1;
            S_SEXT, S_SOP, S_DEXT, S_WR, S_TAIL: begin
                in_bus = 1'b1;
                step   = ack_i;
            end
            S_DONE: step = 1'b1;
            default: step = 1'b1;
        endcase
        if (step) begin
            if (st_q == S_DONE) begin
                st_d   = S_IDLE;
                left_d = '0;
            end else if (st_q == S_IDLE || left_q <= PCW'(1)) begin
                st_d   = next_phase(st_q, plan_cur);
                left_d = cnt_of(st_d, plan_cur);
            end else begin
                left_d = left_q - PCW'(1);
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            left_q <= '0;
            plan_q <= '0;
            sup_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
            if (accept) begin
                plan_q <= plan_in;
                sup_q  <= super_i;
            end
        end
    end

    // Outputs
    always_comb begin
        is_wr   = (st_q == S_WR);
        is_prog = (st_q == S_SEXT) || (st_q == S_DEXT) || (st_q == S_TAIL) ||
                  ((st_q == S_SOP) && plan_q.src_imm);
        idle_o  = (st_q == S_WAIT);
        done_o  = (st_q == S_DONE);
        len_o   = done_o ? cnt : '0;
    end

    move_seq_attr u_attr (
        .in_bus_i  (in_bus),
        .is_wr_i   (is_wr),
        .is_prog_i (is_prog),
        .op_byte_i (plan_q.op_byte),
        .sup_i     (sup_q),
        .valid_o   (req_valid_o),
        .write_o   (req_write_o),
        .prog_o    (req_prog_o),
        .fc_o      (req_fc_o),
        .byte_o    (req_byte_o)
    );

    move_seq_clkcnt #(.W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept),
        .inc_i (idle_o || in_bus),
        .cnt_o (cnt)
    );

endmodule

// File: rtl/move_seq_chk.sv
module move_seq_chk #(
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             req_valid_o,
    input logic             req_write_o,
    input logic             req_prog_o,
    input logic [2:0]       req_fc_o,
    input logic             req_byte_o,
    input logic             idle_o,
    input logic             done_o,
    input logic [LEN_W-1:0] len_o
);

    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !ack_i) |=> (req_valid_o &&
            $stable({req_write_o, req_prog_o, req_fc_o, req_byte_o})));

    a_r6_fc_legal: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_fc_o == 3'd1 || req_fc_o == 3'd2 ||
                         req_fc_o == 3'd5 || req_fc_o == 3'd6));

    a_r6_fc_space: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> ((req_fc_o[1:0] == 2'b10) == req_prog_o));

    a_r5_byte_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_byte_o) |-> !req_prog_o);

    a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !req_valid_o);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (len_o != '0 && !req_valid_o));

endmodule

bind move_seq move_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_prog_o  (req_prog_o),
    .req_fc_o    (req_fc_o),
    .req_byte_o  (req_byte_o),
    .idle_o      (idle_o),
    .done_o      (done_o),
    .len_o       (len_o)
);

// File: tb/sim_move_seq.sv
module sim_move_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] src_class_i = '0;
    logic [1:0] dst_class_i = '0;
    logic [1:0] size_i = '0;
    logic [1:0] src_ext_i = '0;
    logic [2:0] lead_idle_i = '0;
    logic       super_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       req_valid_o, req_write_o, req_prog_o, req_byte_o;
    logic [2:0] req_fc_o;
    logic       idle_o, done_o;
    logic [9:0] len_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit       idle;
        bit       vld;
        bit       wr;
        bit       prog;
        bit [2:0] fc;
        bit       byt;
        bit       ack;
    } rec_t;

    rec_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    move_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_class_i(src_class_i), .dst_class_i(dst_class_i), .size_i(size_i),
        .src_ext_i(src_ext_i), .lead_idle_i(lead_idle_i), .super_i(super_i),
        .ack_i(ack_i), .req_valid_o(req_valid_o), .req_write_o(req_write_o),
        .req_prog_o(req_prog_o), .req_fc_o(req_fc_o), .req_byte_o(req_byte_o),
        .idle_o(idle_o), .done_o(done_o), .len_o(len_o)
    );

    function automatic void push_bus(bit wr, bit prog, bit byt, bit sup, int blen);
        for (int k = 0; k < blen; k++) begin
            rec_t r;
            r.idle = 0; r.vld = 1; r.wr = wr; r.prog = prog; r.byt = byt;
            r.fc   = prog ? (sup ? 3'd6 : 3'd2) : (sup ? 3'd5 : 3'd1);
            r.ack  = (k == blen - 1);
            q.push_back(r);
        end
    endfunction

    // Reference: expected per-clock trace from the requirements
    function automatic void build(int src, int dst, int sz, int ext, int idl,
                                  bit sup, int blen);
        int  nop;
        bit  byt;
        nop = (sz == 2) ? 2 : 1;
        byt = (sz == 0);
        q.delete();
        for (int i = 0; i < idl; i++) begin
            rec_t r;
            r.idle = 1; r.vld = 0; r.wr = 0; r.prog = 0; r.fc = 0; r.byt = 0; r.ack = 0;
            q.push_back(r);
        end
        for (int i = 0; i < ext; i++) push_bus(0, 1, 0, sup, blen);
        if (src == 1)
            for (int i = 0; i < nop; i++) push_bus(0, 1, 0, sup, blen);
        else if (src >= 2)
            for (int i = 0; i < nop; i++) push_bus(0, 0, byt, sup, blen);
        if (src >= 2 && dst == 2) begin
            push_bus(0, 1, 0, sup, blen);
            for (int i = 0; i < nop; i++) push_bus(1, 0, byt, sup, blen);
            push_bus(0, 1, 0, sup, blen);
            push_bus(0, 1, 0, sup, blen);
        end else begin
            if (dst == 2) begin push_bus(0, 1, 0, sup, blen); push_bus(0, 1, 0, sup, blen); end
            if (dst == 3) push_bus(0, 1, 0, sup, blen);
            if (dst != 0)
                for (int i = 0; i < nop; i++) push_bus(1, 0, byt, sup, blen);
            push_bus(0, 1, 0, sup, blen);
        end
    endfunction

    task automatic cmp(rec_t r, string rq, int idx);
        checks++;
        if (req_valid_o !== r.vld || idle_o !== r.idle || done_o !== 1'b0) begin
            failures++;
            $display("FAIL %s clk %0d: valid/idle/done=%b%b%b expected %b%b0",
                     rq, idx, req_valid_o, idle_o, done_o, r.vld, r.idle);
        end else if (r.vld && (req_write_o !== r.wr || req_prog_o !== r.prog)) begin
            failures++;
            $display("FAIL %s clk %0d: write/prog=%b%b expected %b%b",
                     rq, idx, req_write_o, req_prog_o, r.wr, r.prog);
        end else if (r.vld && req_fc_o !== r.fc) begin
            failures++;
            $display("FAIL R6 clk %0d: fc=%0d expected %0d", idx, req_fc_o, r.fc);
        end else if (r.vld && req_byte_o !== r.byt) begin
            failures++;
            $display("FAIL R5 clk %0d: byte=%b expected %b", idx, req_byte_o, r.byt);
        end
    endtask

    task automatic run_case(string rq, int src, int dst, int sz, int ext, int idl,
                            bit sup, int blen, bit stray_ack, bit stray_start,
                            int want_len);
        build(src, dst, sz, ext, idl, sup, blen);
        @(negedge clk);
        src_class_i = src[1:0]; dst_class_i = dst[1:0]; size_i = sz[1:0];
        src_ext_i = ext[1:0]; lead_idle_i = idl[2:0]; super_i = sup;
        start_i = 1'b1;
        @(negedge clk);
        start_i = stray_start;
        if (stray_start) begin
            // R10: changed operands offered while busy must not matter
            src_class_i = 2'd0; dst_class_i = 2'd0; size_i = 2'd2; super_i = ~sup;
        end
        for (int i = 0; i < q.size(); i++) begin
            cmp(q[i], rq, i);
            ack_i = q[i].ack | (q[i].idle & stray_ack);   // R7: stray ack in idle
            @(negedge clk);
        end
        start_i = 1'b0;
        ack_i   = 1'b0;
        checks++;
        if (done_o !== 1'b1 || len_o !== 10'(q.size())) begin
            failures++;
            $display("FAIL R9 done/len=%b/%0d expected 1/%0d", done_o, len_o, q.size());
        end
        if (want_len > 0) begin
            checks++;
            if (len_o !== 10'(want_len)) begin
                failures++;
                $display("FAIL R3 len=%0d expected %0d", len_o, want_len);
            end
        end
        @(negedge clk);
        checks++;
        if (done_o !== 1'b0 || req_valid_o !== 1'b0) begin
            failures++;
            $display("FAIL R9 after done: done/valid=%b%b expected 00", done_o, req_valid_o);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (req_valid_o !== 1'b0 || idle_o !== 1'b0 || done_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: valid/idle/done=%b%b%b expected 000",
                     req_valid_o, idle_o, done_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (req_valid_o !== 1'b0 || idle_o !== 1'b0 || done_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 after release: valid/idle/done=%b%b%b expected 000",
                     req_valid_o, idle_o, done_o);
        end
        // R3: byte, memory source, absolute long, 26 clocks (also R8 idle)
        run_case("R3", 2, 2, 0, 1, 2, 1, 4, 0, 0, 26);
        // R3: word, user mode, single-clock cycles
        run_case("R3", 3, 2, 1, 0, 0, 0, 1, 0, 0, 0);
        // R3: long, stray ack during idle (R7), slow bus
        run_case("R3", 2, 2, 2, 2, 3, 1, 3, 1, 0, 0);
        // R4: register source to absolute long
        run_case("R4", 0, 2, 0, 0, 0, 1, 2, 0, 0, 0);
        // R4: immediate long source to absolute long, user mode
        run_case("R4", 1, 2, 2, 0, 1, 0, 2, 0, 0, 0);
        // R2/R5: memory to indirect, size code 3 acts as word
        run_case("R2", 2, 1, 3, 0, 0, 1, 2, 0, 0, 0);
        // R2: register to register, only closing prefetch
        run_case("R2", 0, 0, 1, 0, 0, 0, 4, 0, 0, 0);
        // R10: immediate byte to absolute short, start held high while busy
        run_case("R10", 1, 3, 0, 2, 1, 1, 2, 1, 1, 0);
        // R2/R8: memory long to register, maximum idle
        run_case("R2", 2, 0, 2, 1, 7, 0, 6, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule